// File: doc/BRIEF.md
# SRAM Regulator Mode Controller

This block chooses the operating mode of an on-chip regulator that powers a group of memory banks. It takes the power state of every bank served by the regulator, the current processor operating-point index and a strap that says which kind of instance it is. A processor-memory instance has three references. A core-memory instance has two. From these inputs it derives a two-bit mode code with no software involvement.

A computed mode that differs from the issued one is sent out as a new mode. A one-cycle request strobe goes with it. The block then stays busy until the regulator reports ready or a programmable settle count runs out. Mode changes that appear while the block is busy are merged. Only the newest computed mode is issued once the block is idle again.

Top module: `sram_ldo_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (normal), `busy_o` is 0 and `req_o` is 0.
- R2: When every bank state field is 2'b00 (off), the computed mode is sleep (2'b11), whatever the operating point or instance kind. Bank i occupies bits [2i+1:2i] of `bank_state_i`. The codes are 2'b00 off, 2'b01 retention, and 2'b10 or 2'b11 on.
- R3: When every bank is in retention (2'b01), the computed mode is retention (2'b10). This takes priority over tracking.
- R4: On a processor instance (`is_cpu_inst_i`=1), the computed mode is tracking (2'b01) when the operating-point index equals OVERDRIVE_OPP (default 2) and the banks are neither all off nor all in retention.
- R5: A core instance (`is_cpu_inst_i`=0) never yields tracking. At the overdrive index it yields normal.
- R6: In every other case the computed mode is normal (2'b00). This covers mixes of on and retention banks at a non-overdrive index, mixes of off and other states, and operating-point indices other than OVERDRIVE_OPP.
- R7: When the block is idle and the computed mode differs from `mode_o`, the next clock edge loads the new mode into `mode_o` and raises `req_o` for exactly one cycle. `mode_o` never changes without `req_o`.
- R8: `busy_o` rises together with `req_o`. It clears at the first later edge at which `ldo_ready_i` is high.
- R9: If `ldo_ready_i` stays low, `busy_o` stays high for `settle_cycles_i`+1 cycles and then clears.
- R10: While `busy_o` is high no new request is issued. Once busy clears, only the newest computed mode is issued, and intermediate modes are never shown on `mode_o`.
- R11: No request is raised while the computed mode equals `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_state_i | input | 2*NUM_BANKS | Per-bank power state codes |
| opp_idx_i | input | OPP_W | Processor operating-point index |
| is_cpu_inst_i | input | 1 | 1: processor-memory instance, 0: core-memory instance |
| ldo_ready_i | input | 1 | Regulator reports the new mode has settled |
| settle_cycles_i | input | SETTLE_W | Settle timeout in cycles (busy lasts this plus one) |
| mode_o | output | 2 | Issued mode: 00 normal, 01 tracking, 10 retention, 11 sleep |
| req_o | output | 1 | One-cycle strobe on every issued mode change |
| busy_o | output | 1 | Transition in progress |

## Verification
Several properties are checked on every cycle by the assertions:
- The request is a single-cycle pulse.
- Busy rises with the request.
- The mode moves only together with the request.
- A core instance never computes tracking.
- All-off and all-retention map to their modes.
- Busy releases on ready or when the count reaches zero.

Some behaviour only the bench scenarios can show:
- The full mode table over bank mixes and operating points.
- The exact length of busy for a given settle count.
- Merging, where an intermediate mode is never issued and the final mode is the newest one.

// File: rtl/ldo_mode_pkg.sv
package ldo_mode_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_TRACK  = 2'b01,
    MODE_RET    = 2'b10,
    MODE_SLEEP  = 2'b11
  } ldo_mode_e;

  localparam logic [1:0] BANK_OFF = 2'b00;
  localparam logic [1:0] BANK_RET = 2'b01;

  function automatic logic bank_is_off(input logic [1:0] code);
    return code == BANK_OFF;
  endfunction

  function automatic logic bank_is_ret(input logic [1:0] code);
    return code == BANK_RET;
  endfunction

  // Priority: sleep, retention, tracking (processor only), normal.
  function automatic ldo_mode_e pick_mode(input logic all_off,
                                          input logic all_ret,
                                          input logic is_cpu,
                                          input logic overdrive);
    if (all_off)                  return MODE_SLEEP;
    else if (all_ret)             return MODE_RET;
    else if (is_cpu && overdrive) return MODE_TRACK;
    else                          return MODE_NORMAL;
  endfunction

endpackage

// File: rtl/ldo_bank_aggregate.sv
module ldo_bank_aggregate #(
  parameter int NUM_BANKS = 4
) (
  input  logic [2*NUM_BANKS-1:0] bank_state_i,
  output logic                   all_off_o,
  output logic                   all_ret_o
);
  import ldo_mode_pkg::*;

  logic [NUM_BANKS-1:0] off_vec;
  logic [NUM_BANKS-1:0] ret_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign off_vec[b] = bank_is_off(bank_state_i[2*b +: 2]);
    assign ret_vec[b] = bank_is_ret(bank_state_i[2*b +: 2]);
  end

  assign all_off_o = &off_vec;
  assign all_ret_o = &ret_vec;
endmodule

// File: rtl/ldo_mode_select.sv
module ldo_mode_select #(
  parameter int OPP_W         = 2,
  parameter int OVERDRIVE_OPP = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     all_off_i,
  input  logic                     all_ret_i,
  input  logic                     is_cpu_i,
  input  logic [OPP_W-1:0]         opp_idx_i,
  output ldo_mode_pkg::ldo_mode_e  target_o
);
  import ldo_mode_pkg::*;

  localparam logic [OPP_W-1:0] OD_IDX = OPP_W'(OVERDRIVE_OPP);

  logic overdrive_w;
  assign overdrive_w = (opp_idx_i == OD_IDX);

  always_comb begin
    target_o = pick_mode(all_off_i, all_ret_i, is_cpu_i, overdrive_w);
  end

  // R5: a core instance never computes tracking
  assert_core_no_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !is_cpu_i |-> target_o != MODE_TRACK);

  // R4: an idle-free overdrive point on a processor instance with active banks tracks
  assert_cpu_track_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_cpu_i && overdrive_w && !all_off_i && !all_ret_i) |-> target_o == MODE_TRACK);
endmodule

// File: rtl/ldo_settle_handshake.sv
module ldo_settle_handshake #(
  parameter int SETTLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                ready_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic                busy_o,
  output logic                expire_o,
  output logic                release_o
);
  logic                busy_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic                cnt_zero_w;

  assign cnt_zero_w = (cnt_q == '0);
  assign expire_o   = busy_q && !ready_i && cnt_zero_w;
  assign release_o  = busy_q && (ready_i || cnt_zero_w);
  assign busy_o     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= settle_i;
    end else if (release_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8: ready seen while busy releases at the next edge
  assert_ready_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ready_i && !start_i) |=> !busy_q);

  // R9: an exhausted settle count releases at the next edge
  assert_timeout_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !start_i) |=> !busy_q);

  // R10: a start is only accepted from idle
  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);
endmodule

// File: rtl/sram_ldo_mode_ctrl.sv
module sram_ldo_mode_ctrl #(
  parameter int NUM_BANKS     = 4,
  parameter int OPP_W         = 2,
  parameter int OVERDRIVE_OPP = 2,
  parameter int SETTLE_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NUM_BANKS-1:0] bank_state_i,
  input  logic [OPP_W-1:0]       opp_idx_i,
  input  logic                   is_cpu_inst_i,
  input  logic                   ldo_ready_i,
  input  logic [SETTLE_W-1:0]    settle_cycles_i,
  output logic [1:0]             mode_o,
  output logic                   req_o,
  output logic                   busy_o
);
  import ldo_mode_pkg::*;

  logic      all_off_w;
  logic      all_ret_w;
  ldo_mode_e target_w;
  ldo_mode_e mode_q;
  logic      req_q;
  logic      issue_w;
  logic      busy_w;
  logic      expire_w;
  logic      release_w;

  ldo_bank_aggregate #(.NUM_BANKS(NUM_BANKS)) u_agg (
    .bank_state_i (bank_state_i),
    .all_off_o    (all_off_w),
    .all_ret_o    (all_ret_w)
  );

  ldo_mode_select #(.OPP_W(OPP_W), .OVERDRIVE_OPP(OVERDRIVE_OPP)) u_sel (
    .clk       (clk),
    .rst_n     (rst_n),
    .all_off_i (all_off_w),
    .all_ret_i (all_ret_w),
    .is_cpu_i  (is_cpu_inst_i),
    .opp_idx_i (opp_idx_i),
    .target_o  (target_w)
  );

  // Merging falls out of issuing only from idle: the target is recomputed
  // every cycle, so the newest value is the one taken when busy clears.
  assign issue_w = !busy_w && (target_w != mode_q);

  ldo_settle_handshake #(.SETTLE_W(SETTLE_W)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (issue_w),
    .ready_i   (ldo_ready_i),
    .settle_i  (settle_cycles_i),
    .busy_o    (busy_w),
    .expire_o  (expire_w),
    .release_o (release_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_NORMAL;
      req_q  <= 1'b0;
    end else begin
      req_q <= issue_w;
      if (issue_w) mode_q <= target_w;
    end
  end

  assign mode_o = mode_q;
  assign req_o  = req_q;
  assign busy_o = busy_w;

  // R7: request lasts a single cycle
  assert_req_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  // R7: mode only moves together with the request
  assert_mode_with_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o |-> $stable(mode_o));

  // R8: busy is raised with the request
  assert_busy_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> busy_o);

  // R2: all banks off selects sleep
  assert_all_off_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    all_off_w |-> target_w == MODE_SLEEP);

  // R3: all banks in retention selects retention
  assert_all_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
    all_ret_w |-> target_w == MODE_RET);

  // R11: no request while the computed mode matches the issued one
  assert_no_idle_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && target_w == mode_q) |=> !req_o);

  // R10: the release and expiry events are never present while idle
  assert_release_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (release_w || expire_w) |-> busy_w);
endmodule

// File: tb/test_sram_ldo_mode_ctrl.sv
`timescale 1ns/1ps
module test_sram_ldo_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] banks = 8'hAA;
  logic [1:0] opp = 2'd0;
  logic       cpu = 1'b1;
  logic       ready = 1'b1;
  logic [7:0] settle = 8'd3;
  logic [1:0] mode;
  logic       req;
  logic       busy;

  int total = 0;
  int bad = 0;
  int req_seen = 0;
  bit ret_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ldo_mode_ctrl #(.NUM_BANKS(NB)) i_sram_ldo_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .bank_state_i(banks), .opp_idx_i(opp),
    .is_cpu_inst_i(cpu), .ldo_ready_i(ready), .settle_cycles_i(settle),
    .mode_o(mode), .req_o(req), .busy_o(busy)
  );

  always @(negedge clk) begin
    if (rst_n && req) req_seen++;
    if (rst_n && mode == 2'b10) ret_seen = 1;
  end

  // {banks[7:0], opp[1:0], cpu, expected mode[1:0]}
  localparam int NV = 13;
  localparam logic [12:0] VEC [NV] = '{
    {8'hAA, 2'd0, 1'b1, 2'b00},
    {8'hAA, 2'd2, 1'b1, 2'b01},
    {8'hAA, 2'd2, 1'b0, 2'b00},
    {8'h55, 2'd2, 1'b1, 2'b10},
    {8'h00, 2'd2, 1'b1, 2'b11},
    {8'h5A, 2'd2, 1'b1, 2'b01},
    {8'h5A, 2'd1, 1'b0, 2'b00},
    {8'h05, 2'd0, 1'b1, 2'b00},
    {8'h55, 2'd0, 1'b0, 2'b10},
    {8'h00, 2'd0, 1'b0, 2'b11},
    {8'hFF, 2'd2, 1'b1, 2'b01},
    {8'hAA, 2'd1, 1'b1, 2'b00},
    {8'hAA, 2'd3, 1'b1, 2'b00}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    banks = 8'hAA; opp = 2'd0; cpu = 1'b1; ready = 1'b1; settle = 8'd3;
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(1);
  endtask

  function automatic string tag_of(input logic [1:0] e, input logic c, input logic [1:0] o);
    if (e == 2'b11) return "R2";
    if (e == 2'b10) return "R3";
    if (e == 2'b01) return "R4";
    if (!c && o == 2'd2) return "R5";
    return "R6";
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int busy_cnt;
    do_reset();
    // R1
    check("R1 mode", mode, 0);
    check("R1 busy", busy, 0);
    check("R1 req", req, 0);

    // Table walk, regulator always ready
    for (int v = 0; v < NV; v++) begin
      banks = VEC[v][12:5]; opp = VEC[v][4:3]; cpu = VEC[v][2];
      wait_neg(5);
      check(tag_of(VEC[v][1:0], VEC[v][2], VEC[v][4:3]), mode, VEC[v][1:0]);
      check("R8 idle after ready", busy, 0);
    end

    // R11: hold inputs, no request
    do_reset();
    req_seen = 0;
    wait_neg(10);
    check("R11 no req when unchanged", req_seen, 0);

    // R7 / R8: change with ready high, single pulse, busy one cycle
    req_seen = 0;
    banks = 8'h00;
    @(negedge clk);
    check("R7 req high", req, 1);
    check("R7 mode loaded", mode, 3);
    check("R8 busy with req", busy, 1);
    @(negedge clk);
    check("R7 req one cycle", req, 0);
    check("R8 busy cleared by ready", busy, 0);
    wait_neg(3);
    check("R7 single request", req_seen, 1);

    // R9: timeout with ready low, settle=5 -> busy 6 cycles
    do_reset();
    ready = 1'b0; settle = 8'd5;
    banks = 8'h55;
    busy_cnt = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (busy) busy_cnt++;
    end
    check("R9 busy length", busy_cnt, 6);
    check("R9 mode retention", mode, 2);

    // R8: ready arrives mid-way
    do_reset();
    ready = 1'b0; settle = 8'd20;
    banks = 8'h00;
    wait_neg(3);
    check("R8 still busy", busy, 1);
    ready = 1'b1;
    @(negedge clk);
    check("R8 released by ready", busy, 0);

    // R10: merge; retention requested mid-transition must never appear
    do_reset();
    ready = 1'b0; settle = 8'd10;
    req_seen = 0; ret_seen = 0;
    opp = 2'd2;
    @(negedge clk);
    check("R10 first issue tracking", mode, 1);
    banks = 8'h55;
    wait_neg(3);
    banks = 8'h00;
    wait_neg(2);
    check("R10 no issue while busy", mode, 1);
    wait_neg(12);
    check("R10 newest mode issued", mode, 3);
    check("R10 two requests", req_seen, 2);
    check("R10 intermediate hidden", int'(ret_seen), 0);

    finish_up();
  end
endmodule